// File: doc/BRIEF.md
# Iterative 512-bit ARX Permutation Core

This core scrambles a 512-bit state made of sixteen 32-bit words through a chosen number of rounds. Each round starts by folding a per-round constant byte into word 0 and a caller-supplied domain byte into word 1. It then rewrites the sixteen words one at a time in ascending order. Each new word is built from two modular additions, two XOR-of-rotations linear layers and two XOR feedbacks from neighbouring words. Because words are rewritten in place, later updates in a round see words that were already rewritten earlier in the same round.

A host presents the state, the domain byte and a round count, then pulses `start`. The core copies the inputs, works on one word per clock, and pulses `done` for one cycle when the last word of the last round has been written. The result stays on `state_out` until the next accepted start.

Top module: `arx512_perm`

## Requirements
- R1: Word k of the state occupies bits 32k+31:32k of `state_in` and `state_out`, so byte 4k+j maps to bits 8j+7:8j of word k.
- R2: At the start of every round, the round constant byte is XORed into bits 7:0 of word 0 and the latched domain byte is XORed into bits 7:0 of word 1.
- R3: Round r (counting from 0) uses constant r of this list: EF, E0, D9, D6, BA, B5, 8C, 83, 10, 1F, 26, 29, 45, 4A, 73, 7C (hex).
- R4: The new word i is computed as follows: t = v[i] + v[i-1]; t ^= rotl(t,24) ^ rotl(t,25); t ^= v[i-2]; t = t + v[i+2]; t ^= rotl(t,9) ^ rotl(t,17); new v[i] = t ^ v[i+1]. Additions are mod 2^32 and indices are mod 16.
- R5: Words are updated in the order i = 0..15, one per clock. Every operand read sees the current register value, which is the value already rewritten in this round for lower indices and the previous round's value otherwise. No other word changes in that cycle.
- R6: For a count N in 1..16 sampled with `start`, exactly N rounds run and `done` is high in the cycle that follows the 16N-th clock edge after the edge that accepted `start`.
- R7: A count of 0 asserts `done` in the cycle after the accepting edge, and `state_out` equals the unchanged `state_in`.
- R8: A count above 16 behaves exactly as a count of 16.
- R9: `start` is ignored while `busy` is high. `busy` and `done` are never high together.
- R10: `done` lasts exactly one cycle, and while the core is idle without a start, `state_out` holds its value.
- R11: After reset, `busy` and `done` are low and `state_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a permutation with the presented inputs (honoured only when idle) |
| state_in | input | 512 | Input state, word k at bits 32k+31:32k |
| domain | input | 8 | Domain byte folded into word 1 each round |
| rounds | input | 8 | Round count; 0 means no rounds, values above 16 are treated as 16 |
| state_out | output | 512 | Current state register, the result after `done` |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The embedded properties assume that `start`, `state_in`, `domain` and `rounds` are clean, known values at each rising edge. They also assume that the host accepts a result as ready only when `done` pulses, not on `busy` falling. The bench changes every input only on the falling clock edge, and it holds the inputs throughout the accepting cycle. During one run it raises a stray start with a different state and count, so that the ignore rule is exercised inside that assumption. It covers counts 0, 1, 4, 16 and 200, with several domain bytes.

// File: rtl/arx512_pkg.sv
// Package: shared sizes, word type and pure helper functions for the
// 512-bit ARX permutation core. Assumes 32-bit words (rotation amounts are
// defined for that width).
package arx512_pkg;
    localparam int WORD_W     = 32;
    localparam int NWORDS     = 16;
    localparam int STATE_W    = WORD_W * NWORDS;
    localparam int IDX_W      = $clog2(NWORDS);
    localparam int MAX_ROUNDS = 16;
    localparam int RND_W      = $clog2(MAX_ROUNDS);
    localparam int CNT_W      = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [RND_W-1:0]  ridx_t;

    // Rotate a word left by a constant amount.
    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Round constant byte for round r.
    function automatic logic [7:0] rc_byte(input ridx_t r);
        case (r)
            4'd0:    return 8'hEF;
            4'd1:    return 8'hE0;
            4'd2:    return 8'hD9;
            4'd3:    return 8'hD6;
            4'd4:    return 8'hBA;
            4'd5:    return 8'hB5;
            4'd6:    return 8'h8C;
            4'd7:    return 8'h83;
            4'd8:    return 8'h10;
            4'd9:    return 8'h1F;
            4'd10:   return 8'h26;
            4'd11:   return 8'h29;
            4'd12:   return 8'h45;
            4'd13:   return 8'h4A;
            4'd14:   return 8'h73;
            default: return 8'h7C;
        endcase
    endfunction
endpackage

// File: rtl/arx512_rc.sv
// Round-constant lookup: maps the running round index to its constant byte.
// Assumes the round index never exceeds MAX_ROUNDS-1.
module arx512_rc
    import arx512_pkg::*;
(
    input  ridx_t      ridx,
    output logic [7:0] rc
);
    // Purely combinational table lookup.
    always_comb begin
        rc = rc_byte(ridx);
    end
endmodule

// File: rtl/arx512_mix.sv
// Word mixing datapath: one full update of a single word from its own value
// and four neighbours. Combinational; the caller supplies operands that
// already reflect in-round updates and any constant injection.
module arx512_mix
    import arx512_pkg::*;
#(
    parameter int ROT_A = 24,
    parameter int ROT_B = 25,
    parameter int ROT_C = 9,
    parameter int ROT_D = 17
) (
    input  word_t w_cur,
    input  word_t w_m1,
    input  word_t w_m2,
    input  word_t w_p1,
    input  word_t w_p2,
    output word_t w_new
);
    word_t sum_a, lin_a, fb_a, sum_b, lin_b;

    // Two add/linear stages with outer and inner feedback.
    always_comb begin
        sum_a = w_cur + w_m1;
        lin_a = sum_a ^ rotl(sum_a, ROT_A) ^ rotl(sum_a, ROT_B);
        fb_a  = lin_a ^ w_m2;
        sum_b = fb_a + w_p2;
        lin_b = sum_b ^ rotl(sum_b, ROT_C) ^ rotl(sum_b, ROT_D);
        w_new = lin_b ^ w_p1;
    end
endmodule

// File: rtl/arx512_seq.sv
// Word/round sequencer: accepts a start when idle, clamps the round count,
// steps the word index every clock and the round index every NWORDS clocks,
// and pulses done at the end. Assumes synchronous inputs.
module arx512_seq
    import arx512_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] rounds,
    output logic             load,
    output logic             busy,
    output logic             done,
    output widx_t            widx,
    output ridx_t            ridx
);
    localparam widx_t LAST_WORD = widx_t'(NWORDS - 1);

    logic [CNT_W-1:0] n_clamped;
    ridx_t            last_round;

    // Accept a start only when idle; clamp the requested count.
    always_comb begin
        load      = start && !busy;
        n_clamped = (rounds > CNT_W'(MAX_ROUNDS)) ? CNT_W'(MAX_ROUNDS) : rounds;
    end

    // Sequencing state: busy flag, indices, final round and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            widx       <= '0;
            ridx       <= '0;
            last_round <= '0;
        end else if (load) begin
            widx       <= '0;
            ridx       <= '0;
            if (n_clamped == '0) begin
                busy       <= 1'b0;
                done       <= 1'b1;
                last_round <= '0;
            end else begin
                busy       <= 1'b1;
                done       <= 1'b0;
                last_round <= ridx_t'(n_clamped - 1'b1);
            end
        end else if (busy) begin
            done <= 1'b0;
            if (widx == LAST_WORD) begin
                widx <= '0;
                if (ridx == last_round) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    ridx <= ridx + 1'b1;
                end
            end else begin
                widx <= widx + 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R10: done is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy and done never overlap.
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: a start while busy does not restart the word sequence.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && widx != LAST_WORD) |=> (busy && widx == $past(widx) + 1'b1));

    // R7: a zero count finishes on the next cycle.
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rounds == '0) |=> (done && !busy));

    // R6: the core stays busy until the last word of a round.
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && widx != LAST_WORD) |=> busy);
endmodule

// File: rtl/arx512_perm.sv
// Iterative 512-bit ARX permutation core (top). Holds the 16-word state,
// selects the five operands of the word being updated, applies the round
// constant and domain injection at word 0 of each round, and writes back one
// word per clock. Assumes start/inputs are synchronous to clk.
module arx512_perm
    import arx512_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] state_in,
    input  logic [7:0]         domain,
    input  logic [CNT_W-1:0]   rounds,
    output logic [STATE_W-1:0] state_out,
    output logic               busy,
    output logic               done
);
    word_t      v [NWORDS];
    logic [7:0] dom_q;
    logic       load;
    widx_t      widx;
    ridx_t      ridx;
    logic [7:0] rc;
    logic       first;
    widx_t      i_m1, i_m2, i_p1, i_p2;
    word_t      op_cur, op_m1, op_m2, op_p1, op_p2, w_new;
    word_t      v1_inj;

    arx512_seq i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rounds (rounds),
        .load   (load),
        .busy   (busy),
        .done   (done),
        .widx   (widx),
        .ridx   (ridx)
    );

    arx512_rc i_rc (
        .ridx (ridx),
        .rc   (rc)
    );

    // Operand selection with wrap-around indices and round-start injection.
    always_comb begin
        first  = busy && (widx == '0);
        i_m1   = widx - 1'b1;
        i_m2   = widx - 2'd2;
        i_p1   = widx + 1'b1;
        i_p2   = widx + 2'd2;
        v1_inj = v[1] ^ {{(WORD_W-8){1'b0}}, dom_q};
        op_cur = first ? (v[0] ^ {{(WORD_W-8){1'b0}}, rc}) : v[widx];
        op_m1  = v[i_m1];
        op_m2  = v[i_m2];
        op_p1  = first ? v1_inj : v[i_p1];
        op_p2  = v[i_p2];
    end

    arx512_mix i_mix (
        .w_cur (op_cur),
        .w_m1  (op_m1),
        .w_m2  (op_m2),
        .w_p1  (op_p1),
        .w_p2  (op_p2),
        .w_new (w_new)
    );

    // Latch the domain byte for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_q <= '0;
        end else if (load) begin
            dom_q <= domain;
        end
    end

    // State register: parallel load, then one in-place word write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NWORDS; k++) v[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < NWORDS; k++) v[k] <= state_in[k*WORD_W +: WORD_W];
        end else if (busy) begin
            v[widx] <= w_new;
            if (first) v[1] <= v1_inj;
        end
    end

    // Present the state little-endian by word.
    generate
        for (genvar k = 0; k < NWORDS; k++) begin : g_out
            assign state_out[k*WORD_W +: WORD_W] = v[k];

            // R5: only the addressed word (and word 1 at round start) changes.
            if (k == 1) begin : g_w1
                p_word_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy && widx != widx_t'(k) && widx != '0) |=> $stable(v[k]));
            end else begin : g_wk
                p_word_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy && widx != widx_t'(k)) |=> $stable(v[k]));
            end
        end
    endgenerate

    // R10: idle without start keeps the output still.
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(state_out));

    // R7: a zero count loads the input unchanged.
    p_zero_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rounds == '0) |=> (state_out == $past(state_in)));

    // R2: word 1 receives the domain byte at the first step of a round.
    p_domain_inject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && widx == '0) |=> (v[1][WORD_W-1:8] == $past(v[1][WORD_W-1:8])));
endmodule

// File: tb/test_arx512_perm.sv
// Bench: cycle-by-cycle behavioural model compared on every clock, plus
// directed end-of-run checks against a whole-permutation function.
module test_arx512_perm;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] state_in = '0;
    logic [7:0]   domain = '0;
    logic [7:0]   rounds = '0;
    logic [511:0] state_out;
    logic         busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    arx512_perm i_arx512_perm (
        .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
        .domain(domain), .rounds(rounds), .state_out(state_out),
        .busy(busy), .done(done)
    );

    always #(PERIOD/2) clk = ~clk;

    byte unsigned rc_tab [16] = '{8'hEF, 8'hE0, 8'hD9, 8'hD6, 8'hBA, 8'hB5, 8'h8C, 8'h83,
                                  8'h10, 8'h1F, 8'h26, 8'h29, 8'h45, 8'h4A, 8'h73, 8'h7C};

    function automatic int unsigned rl(input int unsigned x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // R4 formula, written from the requirement.
    function automatic int unsigned mixw(input int unsigned c, m1, m2, p1, p2);
        int unsigned t;
        t = c + m1;
        t = t ^ rl(t, 24) ^ rl(t, 25);
        t = t ^ m2;
        t = t + p2;
        t = t ^ rl(t, 9) ^ rl(t, 17);
        return t ^ p1;
    endfunction

    // Whole permutation (R1..R5, R8 clamp).
    function automatic logic [511:0] perm(input logic [511:0] s, input byte unsigned dm, input int n);
        int unsigned w [16];
        logic [511:0] r;
        int nn;
        nn = (n > 16) ? 16 : n;
        for (int k = 0; k < 16; k++) w[k] = s[32*k +: 32];
        for (int rr = 0; rr < nn; rr++) begin
            w[0] ^= rc_tab[rr];
            w[1] ^= dm;
            for (int i = 0; i < 16; i++)
                w[i] = mixw(w[i], w[(i+15)%16], w[(i+14)%16], w[(i+1)%16], w[(i+2)%16]);
        end
        for (int k = 0; k < 16; k++) r[32*k +: 32] = w[k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model state.
    int unsigned  m_v [16];
    bit           m_busy, m_done;
    int           m_w, m_r, m_last;
    byte unsigned m_dom;

    function automatic logic [511:0] m_pack();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[32*k +: 32] = m_v[k];
        return r;
    endfunction

    // Model advances on each rising edge from bench-driven inputs only.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) m_v[k] = 0;
            m_busy = 0; m_done = 0; m_w = 0; m_r = 0; m_last = 0; m_dom = 0;
        end else if (m_busy) begin
            m_done = 0;
            if (m_w == 0) begin
                m_v[0] ^= rc_tab[m_r];
                m_v[1] ^= m_dom;
            end
            m_v[m_w] = mixw(m_v[m_w], m_v[(m_w+15)%16], m_v[(m_w+14)%16],
                            m_v[(m_w+1)%16], m_v[(m_w+2)%16]);
            if (m_w == 15) begin
                m_w = 0;
                if (m_r == m_last) begin m_busy = 0; m_done = 1; end
                else m_r++;
            end else m_w++;
        end else begin
            m_done = 0;
            if (start) begin
                int n;
                for (int k = 0; k < 16; k++) m_v[k] = state_in[32*k +: 32];
                m_dom = domain;
                n = (rounds > 16) ? 16 : rounds;
                m_w = 0; m_r = 0;
                if (n == 0) m_done = 1;
                else begin m_busy = 1; m_last = n - 1; end
            end
        end
    end

    // Per-clock comparison (R5 ordering, R6 timing, R9 ignore).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(state_out == m_pack(), "R5 per-cycle state", state_out, m_pack());
            chk(busy == m_busy && done == m_done, "R6 per-cycle busy/done",
                {510'd0, busy, done}, {510'd0, m_busy, m_done});
        end
    end

    function automatic logic [511:0] rnd_state();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
        return r;
    endfunction

    // Run one permutation; returns cycles from accept to done.
    task automatic run(input logic [511:0] s, input byte unsigned dm, input int n, output int cyc);
        @(negedge clk);
        state_in = s; domain = dm; rounds = n[7:0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [511:0] s, exp;
        int cyc;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(state_out == '0 && !busy && !done, "R11 reset", {state_out[509:0], busy, done}, '0);
        rst_n = 1'b1;

        // R1/R2/R4 zero state, one round, domain 0
        s = '0;
        run(s, 8'h00, 1, cyc);
        exp = perm(s, 8'h00, 1);
        chk(state_out == exp, "R1 R2 R4 zero state 1 round", state_out, exp);
        chk(cyc == 16, "R6 cycles for 1 round", cyc, 16);

        // R2 domain injection with random state
        s = rnd_state();
        run(s, 8'hA5, 1, cyc);
        exp = perm(s, 8'hA5, 1);
        chk(state_out == exp, "R2 domain A5 1 round", state_out, exp);

        // R3 several rounds
        s = rnd_state();
        run(s, 8'h3C, 4, cyc);
        exp = perm(s, 8'h3C, 4);
        chk(state_out == exp, "R3 4 rounds", state_out, exp);
        chk(cyc == 64, "R6 cycles for 4 rounds", cyc, 64);

        s = rnd_state();
        run(s, 8'hFF, 16, cyc);
        exp = perm(s, 8'hFF, 16);
        chk(state_out == exp, "R3 R5 16 rounds", state_out, exp);
        chk(cyc == 256, "R6 cycles for 16 rounds", cyc, 256);

        // R7 zero count
        s = rnd_state();
        run(s, 8'h11, 0, cyc);
        chk(state_out == s, "R7 zero count passthrough", state_out, s);
        chk(cyc == 0, "R7 zero count timing", cyc, 0);

        // R8 clamp
        s = rnd_state();
        run(s, 8'h5A, 200, cyc);
        exp = perm(s, 8'h5A, 16);
        chk(state_out == exp, "R8 clamp 200 to 16", state_out, exp);
        chk(cyc == 256, "R8 clamp timing", cyc, 256);

        // R10 one-cycle done and stable output
        @(negedge clk);
        chk(!done, "R10 done pulse width", done, 0);
        repeat (5) @(negedge clk);
        chk(state_out == exp, "R10 idle output stable", state_out, exp);

        // R9 start while busy ignored
        s = rnd_state();
        @(negedge clk);
        state_in = s; domain = 8'h77; rounds = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        state_in = rnd_state(); domain = 8'h01; rounds = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R9 stray start ignored", {busy, done}, 2'b10);
        while (!done) @(negedge clk);
        exp = perm(s, 8'h77, 2);
        chk(state_out == exp, "R9 result unaffected by stray start", state_out, exp);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule